// File: doc/BRIEF.md
# Simultaneous-Format Output Rate FIFO

This block sits between a channel splitter and a multibit audio DAC that takes
simultaneous-format serial data. The splitter delivers words in short bursts at
the fast input bit rate. Each burst is 16 entries, and each entry is a four-lane
slice: a word-boundary marker, one left-channel bit, one right-channel bit and a
spare control bit. The block stores these slices in a 32-entry FIFO and streams
them out without a break at one quarter of the input bit rate. On the output
side the DAC sees a continuous bit clock, one data line for each channel and a
latch-enable line.

The whole block runs from one master clock. `bck_tick` is a one-cycle enable
that marks each input bit period. A slice is written on a cycle where both
`bck_tick` and `wr_en` are high. The output bit clock is made by counting
`bck_tick` pulses. It has four ticks per period: two ticks high, then two ticks
low. The counter is held until the FIFO first holds 16 slices, so a full word is
always buffered before the first read. A read takes place on the tick where the
output clock falls, and the output slice register is loaded in that same cycle.
A half-full flag supports flow control. Sticky flags record a dropped write and
a read from an empty FIFO.

Top module: `simfmt_rate_fifo`

## Requirements
- R1: After a synchronous reset, `dac_bck` is 1, all four DAC lanes are 0, and `half_full`, `ovf_flag` and `udf_flag` are 0.
- R2: A slice is written only on a cycle with `bck_tick`=1 and `wr_en`=1. Lane bit 0 is latch enable (`dac_le`), bit 1 is left data (`dac_l`), bit 2 is right data (`dac_r`) and bit 3 is control (`dac_ctrl`). Slices leave in the order they were written.
- R3: The output clock is held high, and no read occurs, until the FIFO has first held 16 slices. Counting starts on the cycle after the occupancy reaches 16.
- R4: Once counting has started, `dac_bck` changes only on `bck_tick` cycles. Its period is 4 ticks: 2 ticks high, then 2 ticks low.
- R5: The DAC lanes are updated with the oldest stored slice in the same master cycle in which `dac_bck` falls. They hold their value at every other time.
- R6: `half_full` is 1 exactly when the occupancy is 16 or more.
- R7: A write while 32 slices are held is dropped and sets `ovf_flag`, which stays set until reset.
- R8: A read slot that finds the FIFO empty sets `udf_flag`, which stays set until reset. The DAC lanes then repeat the last slice.
- R9: While no `bck_tick` arrives, the stored data, the DAC lanes and `dac_bck` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_tick | input | 1 | One-cycle enable, one per input bit period |
| wr_en | input | 1 | Write qualifier for the current tick |
| wr_lanes | input | 4 | Slice: bit0 LE, bit1 left, bit2 right, bit3 control |
| dac_bck | output | 1 | Continuous output bit clock |
| dac_le | output | 1 | Latch-enable lane |
| dac_l | output | 1 | Left data lane |
| dac_r | output | 1 | Right data lane |
| dac_ctrl | output | 1 | Control lane |
| half_full | output | 1 | Occupancy is 16 or more |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| udf_flag | output | 1 | Sticky: a read found the FIFO empty |

## Verification
Every result is due one master edge after the cycle that caused it. An accepted
write raises the occupancy and `half_full` after that edge. A falling tick of
`dac_bck` and the lane update show together after the same edge, and both flags
set one edge after the offending strobe. The output counter starts one further
edge after the occupancy reaches 16. The bench drives each cycle at the falling
master edge, advances its own queue model by exactly one edge, and compares all
outputs at the next falling edge. Because of this, every expectation is checked
in the cycle the result is due.

// File: rtl/simfmt_pkg.sv
package simfmt_pkg;

    typedef struct packed {
        logic ctrl;
        logic right;
        logic left;
        logic le;
    } lane_t;

    localparam int unsigned LANES       = 4;
    localparam int unsigned FIFO_DEPTH  = 32;
    localparam int unsigned CLK_DIVIDE  = 4;

    // level of the divided clock for a given phase count
    function automatic logic phase_is_high(input int unsigned ph, input int unsigned div);
        return ph < (div / 2);
    endfunction

    // next phase with wrap at the divide ratio
    function automatic int unsigned phase_next(input int unsigned ph, input int unsigned div);
        return (ph == div - 1) ? 0 : ph + 1;
    endfunction

endpackage

// File: rtl/sf_lane_store.sv
module sf_lane_store
    import simfmt_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    localparam int unsigned PTRW = $clog2(DEPTH),
    localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_req,
    input  lane_t           wr_word,
    input  logic            rd_req,
    output lane_t           head_word,
    output logic            not_empty,
    output logic [LVLW-1:0] level,
    output logic            ovf,
    output logic            udf
);
    localparam logic [LVLW-1:0] FULL_LVL = LVLW'(DEPTH);
    localparam logic [PTRW-1:0] LAST_PTR = PTRW'(DEPTH - 1);

    lane_t           mem [DEPTH];
    logic [PTRW-1:0] wp, rp;
    logic            wr_go, rd_go;

    assign not_empty = (level != '0);
    assign wr_go     = wr_req && (level != FULL_LVL);
    assign rd_go     = rd_req && not_empty;
    assign head_word = mem[rp];

    always_ff @(posedge clk) begin
        if (wr_go) mem[wp] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            ovf   <= 1'b0;
            udf   <= 1'b0;
        end else begin
            if (wr_go) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            if (rd_go) rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            if (wr_go && !rd_go)      level <= level + 1'b1;
            else if (rd_go && !wr_go) level <= level - 1'b1;
            if (wr_req && !wr_go) ovf <= 1'b1;
            if (rd_req && !rd_go) udf <= 1'b1;
        end
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (level == $past(level)) || (level == $past(level) + 1'b1) || (level + 1'b1 == $past(level)));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ovf) |-> ovf);

    // R8
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(udf) |-> udf);

endmodule

// File: rtl/sf_bit_divider.sv
module sf_bit_divider
    import simfmt_pkg::*;
#(
    parameter int unsigned DIV = CLK_DIVIDE,
    localparam int unsigned PW = (DIV > 2) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic arm,
    output logic bck,
    output logic rd_slot
);
    localparam logic [PW-1:0] FALL_PH = PW'(DIV / 2 - 1);

    logic [PW-1:0] ph;
    logic          running;

    assign bck     = phase_is_high(int'(ph), DIV);
    assign rd_slot = running && tick && (ph == FALL_PH);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= '0;
            running <= 1'b0;
        end else begin
            if (running && tick) ph <= PW'(phase_next(int'(ph), DIV));
            if (arm) running <= 1'b1;
        end
    end

    // R3
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(running) |-> running);

endmodule

// File: rtl/sf_out_stage.sv
module sf_out_stage
    import simfmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  lane_t word_in,
    output lane_t word_q
);
    always_ff @(posedge clk) begin
        if (rst)       word_q <= '0;
        else if (load) word_q <= word_in;
    end
endmodule

// File: rtl/simfmt_rate_fifo.sv
module simfmt_rate_fifo
    import simfmt_pkg::*;
#(
    parameter int unsigned DEPTH = FIFO_DEPTH,
    parameter int unsigned DIV   = CLK_DIVIDE,
    localparam int unsigned LVLW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bck_tick,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_lanes,
    output logic             dac_bck,
    output logic             dac_le,
    output logic             dac_l,
    output logic             dac_r,
    output logic             dac_ctrl,
    output logic             half_full,
    output logic             ovf_flag,
    output logic             udf_flag
);
    localparam logic [LVLW-1:0] HALF_LVL = LVLW'(DEPTH / 2);

    lane_t           head, out_word;
    logic            not_empty, rd_slot;
    logic [LVLW-1:0] level;

    assign half_full = (level >= HALF_LVL);

    sf_lane_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_req(bck_tick && wr_en), .wr_word(lane_t'(wr_lanes)),
        .rd_req(rd_slot), .head_word(head), .not_empty(not_empty),
        .level(level), .ovf(ovf_flag), .udf(udf_flag)
    );

    sf_bit_divider #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .tick(bck_tick), .arm(half_full),
        .bck(dac_bck), .rd_slot(rd_slot)
    );

    sf_out_stage u_out (
        .clk(clk), .rst(rst), .load(rd_slot && not_empty),
        .word_in(head), .word_q(out_word)
    );

    assign dac_le   = out_word.le;
    assign dac_l    = out_word.left;
    assign dac_r    = out_word.right;
    assign dac_ctrl = out_word.ctrl;

    // R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(dac_bck) |-> $stable(out_word));

    // R9
    bck_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bck_tick) |-> $stable(dac_bck));

endmodule

// File: tb/sim_simfmt_rate_fifo.sv
module sim_simfmt_rate_fifo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bck_tick = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_lanes = 4'h0;
    logic dac_bck, dac_le, dac_l, dac_r, dac_ctrl, half_full, ovf_flag, udf_flag;

    always #2.5 clk = ~clk;

    simfmt_rate_fifo u0 (
        .clk(clk), .rst(rst), .bck_tick(bck_tick), .wr_en(wr_en), .wr_lanes(wr_lanes),
        .dac_bck(dac_bck), .dac_le(dac_le), .dac_l(dac_l), .dac_r(dac_r),
        .dac_ctrl(dac_ctrl), .half_full(half_full), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
    );

    // frame pattern: bit0 LE, bit1 left, bit2 right, bit3 control
    localparam logic [3:0] VEC [16] = '{
        4'h3, 4'h4, 4'h2, 4'h6, 4'h8, 4'hA, 4'hC, 4'hE,
        4'h0, 4'h6, 4'h2, 4'h4, 4'h8, 4'hE, 4'h2, 4'hC
    };

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference queue model
    logic [3:0] m_q [32];
    int m_hd, m_tl, m_cnt, m_ph;
    bit m_run, m_ovf, m_udf;
    logic [3:0] m_out;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] dac_word();
        return {dac_ctrl, dac_r, dac_l, dac_le};
    endfunction

    task automatic model_reset();
        m_hd = 0; m_tl = 0; m_cnt = 0; m_ph = 0;
        m_run = 0; m_ovf = 0; m_udf = 0; m_out = 4'h0;
    endtask

    // one master cycle: drive at negedge, model one edge, compare at next negedge
    task automatic step(input bit t, input bit w, input logic [3:0] d);
        int c0;
        bit wr, rd, hf_pre, wr_ok, rd_ok;
        bck_tick = t; wr_en = w; wr_lanes = d;
        c0 = m_cnt;
        wr = t && w;
        rd = m_run && t && (m_ph == 1);
        hf_pre = (c0 >= 16);
        wr_ok = wr && (c0 < 32);
        rd_ok = rd && (c0 > 0);
        if (wr && !wr_ok) m_ovf = 1;
        if (rd && !rd_ok) m_udf = 1;
        if (rd_ok) begin m_out = m_q[m_hd]; m_hd = (m_hd + 1) % 32; end
        if (wr_ok) begin m_q[m_tl] = d; m_tl = (m_tl + 1) % 32; end
        m_cnt = c0 + int'(wr_ok) - int'(rd_ok);
        if (m_run && t) m_ph = (m_ph + 1) % 4;
        m_run = m_run | hf_pre;
        @(posedge clk);
        @(negedge clk);
        chk("R4 dac_bck", int'(dac_bck), int'(m_ph < 2));
        chk("R2/R5 lanes", int'(dac_word()), int'(m_out));
        chk("R6 half_full", int'(half_full), int'(m_cnt >= 16));
        chk("R7 ovf_flag", int'(ovf_flag), int'(m_ovf));
        chk("R8 udf_flag", int'(udf_flag), int'(m_udf));
    endtask

    task automatic do_reset();
        rst = 1'b1; bck_tick = 0; wr_en = 0; wr_lanes = 4'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        // R1
        chk("R1 dac_bck", int'(dac_bck), 1);
        chk("R1 lanes", int'(dac_word()), 0);
        chk("R1 half_full", int'(half_full), 0);
        chk("R1 ovf_flag", int'(ovf_flag), 0);
        chk("R1 udf_flag", int'(udf_flag), 0);
    endtask

    initial begin
        logic [3:0] held;
        @(negedge clk);
        do_reset();

        // R3: 15 slices, no reads, clock held high
        for (int i = 0; i < 15; i++) begin
            step(1, 1, VEC[i]);
            chk("R3 clock held", int'(dac_bck), 1);
        end
        chk("R3 lanes idle", int'(dac_word()), 0);

        // table walk: bursts of 16 then 48 idle ticks, tick every other cycle
        for (int f = 0; f < 6; f++) begin
            for (int i = 0; i < 64; i++) begin
                step(1, i < 16, VEC[(i + 4 * f) % 16]);
                step(0, 1, 4'hF);  // write without tick ignored (R2)
            end
        end

        // R9: no ticks, nothing moves
        held = dac_word();
        for (int i = 0; i < 40; i++) step(0, 1, 4'h5);
        chk("R9 lanes held", int'(dac_word()), int'(held));

        // R7: continuous writes overflow
        for (int i = 0; i < 60; i++) step(1, 1, VEC[i % 16]);
        chk("R7 overflow seen", int'(ovf_flag), 1);
        chk("R6 full half_full", int'(half_full), 1);

        // R8: drain until empty then repeat last slice
        for (int i = 0; i < 200; i++) step(1, 0, 4'h0);
        chk("R8 underflow seen", int'(udf_flag), 1);
        held = dac_word();
        for (int i = 0; i < 8; i++) step(1, 0, 4'h0);
        chk("R8 last slice repeated", int'(dac_word()), int'(held));

        // R1 again after mid-run reset
        do_reset();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule